// File: doc/BRIEF.md
# Asynchronous External Memory Timing Engine

This block handles one transfer at a time between an internal requester and external asynchronous SRAM, ROM or NOR flash. Each access is built from up to four phases, and each phase length is counted in system-clock cycles: an address setup phase, an address hold phase (multiplexed buses only), a data phase with the read or write strobe held low, and a turnaround gap. Every bank has its own active-low chip select. The address lines, the data lines and the strobes are shared by all banks.

Requests use a valid/ready handshake. `req_ready` is high only while the engine is idle. A request that is presented while `req_ready` is low waits, held by the requester. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse and must be captured in that cycle. Timing comes from static configuration inputs. Reads always use the primary timing set. Writes use the secondary set when extended mode is on, and the primary set otherwise. The set and the bus options are sampled when a request is accepted.

The data pins are split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`, with the tri-state buffer placed at the pad. In multiplexed mode the address travels on the data lines ahead of the data phase and is marked by an active-low address-valid pulse.

Top module: `async_mem_engine`

## Requirements
- R1: After reset, all chip selects, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are high, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at clock edge 0 gets a setup phase covering cycles 1 to S, where S is the setup value from 0 to 15. A value of 0 skips the phase. The strobe first goes low in cycle S+H+1.
- R3: The hold phase exists only when `cfg_mux` is 1. It lasts H cycles, with values from 1 to 15, and a programmed 0 is treated as 1. With `cfg_mux` at 0, H is 0.
- R4: The data phase lasts D cycles, with values from 1 to 255, and a programmed 0 is treated as 1. For a write, `mem_we_n` is low for exactly D cycles. For a read, `mem_oe_n` is low for exactly D cycles. The other strobe stays high.
- R5: After the data phase, T turnaround cycles follow (0 to 15). `req_ready` rises again in cycle S+H+D+T+1.
- R6: With `cfg_ext_mode` at 1, writes use the `cfg_wr_*` timing set and reads use `cfg_rd_*`. With `cfg_ext_mode` at 0, both directions use `cfg_rd_*`.
- R7: During setup, hold and data, exactly the chip select `mem_cs_n[req_bank]` is low and `mem_addr` equals the request address. All chip selects are high at every other time.
- R8: `cfg_width` selects the external data width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Write data is driven masked to that width. Read data is returned zero-extended from that width.
- R9: A write to a bank whose `cfg_bank_wen` bit is 0 gives `rsp_valid` with `rsp_err`=1 in cycle 1. No chip select, strobe or data drive occurs, and `req_ready` stays high.
- R10: In multiplexed mode, the address (zero-extended) is driven on `mem_dq_out` with `mem_dq_oe`=1 during setup and hold, and `mem_adv_n` is low for exactly the S setup cycles. At all other times, `mem_dq_oe` is 1 only during a write data phase.
- R11: Read data is sampled from `mem_dq_in` on the last data-phase cycle. `rsp_valid` pulses once in cycle S+H+D+1 with `rsp_err`=0.
- R12: `req_ready` is low from the cycle after acceptance until the turnaround ends. Only one transfer is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Bank index |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a blocked write |
| rsp_rdata | output | DW | Read data, zero-extended |
| cfg_ext_mode | input | 1 | Writes use the separate timing set |
| cfg_mux | input | 1 | Address/data multiplexed bus |
| cfg_width | input | 2 | External data width code |
| cfg_bank_wen | input | NBANK | Per-bank write permission |
| cfg_rd_setup | input | 4 | Primary setup cycles |
| cfg_rd_hold | input | 4 | Primary hold cycles |
| cfg_rd_data | input | 8 | Primary data cycles |
| cfg_rd_turn | input | 4 | Primary turnaround cycles |
| cfg_wr_setup | input | 4 | Write setup cycles (extended mode) |
| cfg_wr_hold | input | 4 | Write hold cycles (extended mode) |
| cfg_wr_data | input | 8 | Write data cycles (extended mode) |
| cfg_wr_turn | input | 4 | Write turnaround cycles (extended mode) |
| mem_cs_n | output | NBANK | Per-bank active-low chip selects |
| mem_addr | output | AW | Shared address lines |
| mem_adv_n | output | 1 | Active-low address-valid pulse |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DW | Data lines, outbound |
| mem_dq_oe | output | 1 | Drive enable for the data lines |
| mem_dq_in | input | DW | Data lines, inbound |

## Verification
The main function is tried with directed minimal timings (all phases at their lowest values), with zero-valued hold and data fields that must clamp to 1, and with the longest data phase. Together these separate an off-by-one in any phase counter from a skipped or clamped phase. Extended-mode writes and reads are run against distinct primary and write timing sets, which shows whether the correct set was picked. Blocked writes, each width code and every bank exercise the error path, the width masking and the chip-select decode. Seeded random timings on mixed multiplexed and plain buses then cross all of these. The bench drives a decoy value on the inbound data except in the last data cycle, so sampling in any other cycle shows up as wrong read data.

// File: rtl/amt_pkg.sv
package amt_pkg;
  localparam int SHORT_W = 4;   // setup, hold, turnaround fields
  localparam int LONG_W  = 8;   // data-phase field

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HOLD,
    PH_DATA,
    PH_TURN
  } phase_e;

  typedef struct packed {
    logic [SHORT_W-1:0] setup;
    logic [SHORT_W-1:0] hold;
    logic [LONG_W-1:0]  data;
    logic [SHORT_W-1:0] turn;
  } timing_s;
endpackage

// File: rtl/amt_phase_seq.sv
module amt_phase_seq
  import amt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bank,
  input  logic             cfg_ext_mode,
  input  logic             cfg_mux,
  input  logic [NBANK-1:0] cfg_bank_wen,
  input  timing_s          rd_tim,
  input  timing_s          wr_tim,
  output phase_e           phase,
  output logic             accept,
  output logic             last_data,
  output logic             wr_q,
  output logic             mux_q,
  output logic [BW-1:0]    bank_q,
  output logic             rsp_valid,
  output logic             rsp_err
);
  phase_e             state_q;
  logic [LONG_W-1:0]  cnt_q;
  timing_s            tim_q;
  timing_s            pick;
  logic               blocked;

  // Choose the timing set, then raise hold and data to their minimum of 1.
  always_comb begin
    pick = (cfg_ext_mode && req_write) ? wr_tim : rd_tim;
    if (pick.hold == '0) pick.hold = SHORT_W'(1);
    if (pick.data == '0) pick.data = LONG_W'(1);
  end

  assign accept    = req_valid && (state_q == PH_IDLE);
  assign blocked   = accept && req_write && !cfg_bank_wen[req_bank];
  assign last_data = (state_q == PH_DATA) && (cnt_q == LONG_W'(1));
  assign phase     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      tim_q     <= '0;
      wr_q      <= 1'b0;
      mux_q     <= 1'b0;
      bank_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= blocked || last_data;
      rsp_err   <= blocked;
      case (state_q)
        PH_IDLE: begin
          if (accept && !blocked) begin
            tim_q  <= pick;
            wr_q   <= req_write;
            mux_q  <= cfg_mux;
            bank_q <= req_bank;
            if (pick.setup != '0) begin
              state_q <= PH_SETUP;
              cnt_q   <= LONG_W'(pick.setup);
            end else if (cfg_mux) begin
              state_q <= PH_HOLD;
              cnt_q   <= LONG_W'(pick.hold);
            end else begin
              state_q <= PH_DATA;
              cnt_q   <= pick.data;
            end
          end
        end
        PH_SETUP: begin
          if (cnt_q == LONG_W'(1)) begin
            if (mux_q) begin
              state_q <= PH_HOLD;
              cnt_q   <= LONG_W'(tim_q.hold);
            end else begin
              state_q <= PH_DATA;
              cnt_q   <= tim_q.data;
            end
          end else begin
            cnt_q <= cnt_q - LONG_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_q == LONG_W'(1)) begin
            state_q <= PH_DATA;
            cnt_q   <= tim_q.data;
          end else begin
            cnt_q <= cnt_q - LONG_W'(1);
          end
        end
        PH_DATA: begin
          if (cnt_q == LONG_W'(1)) begin
            if (tim_q.turn != '0) begin
              state_q <= PH_TURN;
              cnt_q   <= LONG_W'(tim_q.turn);
            end else begin
              state_q <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - LONG_W'(1);
          end
        end
        PH_TURN: begin
          if (cnt_q == LONG_W'(1)) state_q <= PH_IDLE;
          else                     cnt_q   <= cnt_q - LONG_W'(1);
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amt_bus_drive.sv
module amt_bus_drive
  import amt_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    cfg_width,
  input  phase_e        phase,
  input  logic          wr_q,
  input  logic          mux_q,
  input  logic          last_data,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] width_mask;
  logic          addr_phase;

  always_comb begin
    case (cfg_width)
      2'd0:    width_mask = DW'(8'hFF);
      2'd1:    width_mask = DW'(16'hFFFF);
      default: width_mask = '1;
    endcase
  end

  assign addr_phase = mux_q && ((phase == PH_SETUP) || (phase == PH_HOLD));
  assign mem_dq_oe  = addr_phase || ((phase == PH_DATA) && wr_q);
  assign mem_dq_out = addr_phase ? DW'(mem_addr) : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      wdata_q   <= '0;
      mask_q    <= '1;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata & width_mask;
        mask_q   <= width_mask;
      end
      if (last_data && !wr_q) rsp_rdata <= mem_dq_in & mask_q;
    end
  end
endmodule

// File: rtl/amt_strobe_gen.sv
module amt_strobe_gen
  import amt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  phase_e           phase,
  input  logic             wr_q,
  input  logic             mux_q,
  input  logic [BW-1:0]    bank_q,
  output logic [NBANK-1:0] mem_cs_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n
);
  logic busy;

  assign busy = (phase == PH_SETUP) || (phase == PH_HOLD) || (phase == PH_DATA);

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign mem_cs_n[b] = !(busy && (bank_q == BW'(b)));
  end

  assign mem_adv_n = !(mux_q && (phase == PH_SETUP));
  assign mem_oe_n  = !((phase == PH_DATA) && !wr_q);
  assign mem_we_n  = !((phase == PH_DATA) && wr_q);
endmodule

// File: rtl/async_mem_engine.sv
module async_mem_engine
  import amt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 32,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [BW-1:0]      req_bank,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DW-1:0]      rsp_rdata,
  input  logic               cfg_ext_mode,
  input  logic               cfg_mux,
  input  logic [1:0]         cfg_width,
  input  logic [NBANK-1:0]   cfg_bank_wen,
  input  logic [SHORT_W-1:0] cfg_rd_setup,
  input  logic [SHORT_W-1:0] cfg_rd_hold,
  input  logic [LONG_W-1:0]  cfg_rd_data,
  input  logic [SHORT_W-1:0] cfg_rd_turn,
  input  logic [SHORT_W-1:0] cfg_wr_setup,
  input  logic [SHORT_W-1:0] cfg_wr_hold,
  input  logic [LONG_W-1:0]  cfg_wr_data,
  input  logic [SHORT_W-1:0] cfg_wr_turn,
  output logic [NBANK-1:0]   mem_cs_n,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_adv_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [DW-1:0]      mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DW-1:0]      mem_dq_in
);
  phase_e        phase;
  logic          accept, last_data, wr_q, mux_q;
  logic [BW-1:0] bank_q;
  timing_s       rd_tim, wr_tim;

  assign rd_tim    = '{setup: cfg_rd_setup, hold: cfg_rd_hold, data: cfg_rd_data, turn: cfg_rd_turn};
  assign wr_tim    = '{setup: cfg_wr_setup, hold: cfg_wr_hold, data: cfg_wr_data, turn: cfg_wr_turn};
  assign req_ready = (phase == PH_IDLE);

  amt_phase_seq #(.NBANK(NBANK), .BW(BW)) u_seq (
    .clk, .rst_n, .req_valid, .req_write, .req_bank, .cfg_ext_mode, .cfg_mux,
    .cfg_bank_wen, .rd_tim, .wr_tim, .phase, .accept, .last_data, .wr_q,
    .mux_q, .bank_q, .rsp_valid, .rsp_err
  );

  amt_bus_drive #(.AW(AW), .DW(DW)) u_bus (
    .clk, .rst_n, .accept, .req_addr, .req_wdata, .cfg_width, .phase, .wr_q,
    .mux_q, .last_data, .mem_dq_in, .mem_addr, .mem_dq_out, .mem_dq_oe, .rsp_rdata
  );

  amt_strobe_gen #(.NBANK(NBANK), .BW(BW)) u_strb (
    .phase, .wr_q, .mux_q, .bank_q, .mem_cs_n, .mem_adv_n, .mem_oe_n, .mem_we_n
  );
endmodule

// File: rtl/amt_checker.sv
module amt_checker #(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [BW-1:0]    req_bank,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             cfg_bank_wen_b,
  input logic [NBANK-1:0] mem_cs_n,
  input logic             mem_adv_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             mem_dq_oe
);
  // R7: never more than one bank selected
  a_r7_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R4: read and write strobes are exclusive, and each needs a chip select
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_oe_n != mem_we_n) && !(&mem_cs_n));

  // R10: no drive while the memory drives the bus
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R10: address pulse comes with the address on the data lines
  a_r10_adv_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> mem_dq_oe && !(&mem_cs_n));

  // R9: blocked write answers next cycle with the error flag
  a_r9_blocked_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !cfg_bank_wen_b) |=> rsp_valid && rsp_err);

  // R12: engine is busy while any chip select is low
  a_r12_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_cs_n) |-> !req_ready);
endmodule

bind async_mem_engine amt_checker #(.NBANK(NBANK), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_bank(req_bank), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .cfg_bank_wen_b(cfg_bank_wen[req_bank]),
  .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/async_mem_engine_tb.sv
module async_mem_engine_tb;
  localparam int NBANK = 4;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic cfg_ext_mode = 0, cfg_mux = 0;
  logic [1:0] cfg_width = 2;
  logic [NBANK-1:0] cfg_bank_wen = '1;
  logic [3:0] cfg_rd_setup = 0, cfg_rd_hold = 0, cfg_rd_turn = 0;
  logic [7:0] cfg_rd_data = 1;
  logic [3:0] cfg_wr_setup = 15, cfg_wr_hold = 15, cfg_wr_turn = 15;
  logic [7:0] cfg_wr_data = 255;
  logic [NBANK-1:0] mem_cs_n;
  logic [AW-1:0] mem_addr;
  logic mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  async_mem_engine #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_dut (.*);

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wmask(logic [1:0] w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic run_acc(bit wr, int bank, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] rv);
    int s, h, d, t, n_adv = 0, n_cs = 0, n_we = 0, n_oe = 0, n_dqoe = 0, n_rsp = 0;
    int first_st = 0, rsp_at = 0, rdy_at = 0, early_rdy = 0;
    bit use_w, blocked, cs_bad = 0, addr_bad = 0, dq_bad = 0, got_err = 0;
    logic [DW-1:0] got_rd = 0, m;
    m = wmask(cfg_width);
    use_w = wr && cfg_ext_mode;
    s = use_w ? cfg_wr_setup : cfg_rd_setup;
    h = use_w ? cfg_wr_hold  : cfg_rd_hold;
    d = use_w ? cfg_wr_data  : cfg_rd_data;
    t = use_w ? cfg_wr_turn  : cfg_rd_turn;
    if (h == 0) h = 1;
    if (!cfg_mux) h = 0;
    if (d == 0) d = 1;
    blocked = wr && !cfg_bank_wen[bank];
    @(negedge clk);
    chk(req_ready, "R12 ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_bank = 2'(bank); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_wdata = ~wd;
    for (int k = 1; k < 700; k++) begin
      mem_dq_in = ~rv;
      if (!mem_adv_n) begin
        n_adv++;
        if (!mem_dq_oe || mem_dq_out != DW'(a)) dq_bad = 1;
      end
      if (mem_cs_n != '1) begin
        n_cs++;
        if (mem_cs_n != ~(NBANK'(1) << bank)) cs_bad = 1;
        if (mem_addr != a) addr_bad = 1;
      end
      if (!mem_we_n) begin
        n_we++;
        if (first_st == 0) first_st = k;
        if (mem_dq_out != (wd & m)) dq_bad = 1;
      end
      if (!mem_oe_n) begin
        n_oe++;
        if (first_st == 0) first_st = k;
        if (n_oe == d) mem_dq_in = rv;
      end
      if (mem_dq_oe) n_dqoe++;
      if (rsp_valid) begin
        n_rsp++;
        if (rsp_at == 0) begin rsp_at = k; got_rd = rsp_rdata; got_err = rsp_err; end
      end
      if (req_ready && rsp_at == 0) early_rdy++;
      if (req_ready && rsp_at != 0) begin rdy_at = k; break; end
      @(negedge clk);
    end
    if (blocked) begin
      chk(rsp_at == 1 && got_err, "R9 blocked write response", rsp_at, 1);
      chk(n_cs == 0 && n_we == 0 && n_dqoe == 0, "R9 blocked write no bus activity", n_cs + n_we + n_dqoe, 0);
      chk(rdy_at == 1, "R9 ready stays high", rdy_at, 1);
    end else begin
      chk(rsp_at == s + h + d + 1, "R11 response cycle", rsp_at, s + h + d + 1);
      chk(n_rsp == 1 && !got_err, "R11 single pulse no error", n_rsp, 1);
      chk(first_st == s + h + 1, "R2 strobe start after setup/hold", first_st, s + h + 1);
      chk(n_adv == (cfg_mux ? s : 0), "R10 address-valid length", n_adv, cfg_mux ? s : 0);
      chk(n_cs == s + h + d, "R3 chip select span", n_cs, s + h + d);
      chk((wr ? n_we : n_oe) == d && (wr ? n_oe : n_we) == 0, "R4 strobe length", wr ? n_we : n_oe, d);
      chk(rdy_at == s + h + d + t + 1, "R5 turnaround before ready", rdy_at, s + h + d + t + 1);
      chk(early_rdy == 0, "R12 ready low during access", early_rdy, 0);
      chk(!cs_bad && !addr_bad, "R7 bank select and address", {cs_bad, addr_bad}, 0);
      chk(!dq_bad, "R8 driven data value", dq_bad, 0);
      chk(n_dqoe == (cfg_mux ? s + h : 0) + (wr ? d : 0), "R10 data bus drive span", n_dqoe,
          (cfg_mux ? s + h : 0) + (wr ? d : 0));
      if (!wr) chk(got_rd == (rv & m), "R8 R11 read data", got_rd, rv & m);
    end
  endtask

  task automatic set_rd(int s, int h, int d, int t);
    cfg_rd_setup = 4'(s); cfg_rd_hold = 4'(h); cfg_rd_data = 8'(d); cfg_rd_turn = 4'(t);
  endtask
  task automatic set_wr(int s, int h, int d, int t);
    cfg_wr_setup = 4'(s); cfg_wr_hold = 4'(h); cfg_wr_data = 8'(d); cfg_wr_turn = 4'(t);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(mem_cs_n == '1 && mem_oe_n && mem_we_n && mem_adv_n, "R1 reset strobes", mem_cs_n, 4'hF);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 reset bus and handshake", {mem_dq_oe, rsp_valid, req_ready}, 1);
    @(negedge clk) rst_n = 1;

    // minimal timing, plain bus, read
    set_rd(0, 0, 1, 0);
    run_acc(0, 0, 24'h123456, 0, 32'hCAFE_F00D);
    // zero fields clamp; multiplexed write, 8-bit width
    cfg_mux = 1; cfg_width = 0; set_rd(2, 0, 0, 1);
    run_acc(1, 1, 24'h00ABCD, 32'h1122_3344, 0);
    // longest data phase, 16-bit read
    cfg_mux = 0; cfg_width = 1; set_rd(15, 3, 255, 15);
    run_acc(0, 3, 24'hFFFFFF, 0, 32'h8765_4321);
    // extended mode: R6 write uses the write set, read keeps the primary set
    cfg_width = 2; cfg_ext_mode = 1; set_rd(1, 1, 2, 1); set_wr(4, 2, 7, 3);
    run_acc(1, 2, 24'h000010, 32'hDEAD_BEEF, 0);
    run_acc(0, 2, 24'h000020, 0, 32'h0BAD_CAFE);
    cfg_ext_mode = 0;
    run_acc(1, 2, 24'h000030, 32'h5555_AAAA, 0);  // R6 primary set for writes
    // R9 blocked write, then the same bank still reads
    cfg_bank_wen = 4'b1101;
    run_acc(1, 1, 24'h000040, 32'hFFFF_FFFF, 0);
    run_acc(0, 1, 24'h000044, 0, 32'h1357_9BDF);
    cfg_bank_wen = '1;

    for (int i = 0; i < 60; i++) begin
      cfg_mux = 1'($urandom);
      cfg_ext_mode = 1'($urandom);
      cfg_width = 2'($urandom);
      cfg_bank_wen = 4'($urandom) | 4'b0001;
      set_rd($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 20), $urandom_range(0, 15));
      set_wr($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 20), $urandom_range(0, 15));
      run_acc(1'($urandom), $urandom_range(0, 3), 24'($urandom), $urandom, $urandom);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule